// File: doc/BRIEF.md
# MIDI Note Command Parser

This block sits after a serial byte receiver and watches the incoming MIDI byte stream for note commands. For every complete note command it latches the key number and the velocity into output registers and raises a one-clock pulse. The pulse is on a note-on line or a note-off line, depending on the command. Everything else in the stream is dropped without any output activity. That covers controller changes, program changes, pressure, pitch bend, system common and exclusive bytes, and real-time clock bytes.

Both wire encodings of a released key end on the same note-off line. One encoding is a note-off status byte with any velocity. The other is a note-on status byte whose velocity is zero. Running status is honoured, so a keyboard can send a status byte once and then repeat key/velocity pairs. Control is a four-state machine held in one-hot form. It drives a small datapath through a struct of load and commit strobes.

Top module: `midi_note_parser`

## Requirements
- R1: A synchronous reset clears both pulse lines, sets the key and velocity outputs to zero and forgets any running status. Data bytes that arrive after reset, with no status byte before them, produce no pulse.
- R2: A status byte with upper nibble 0x9, followed by a key byte and a nonzero velocity byte, gives a note-on pulse. The pulse comes in the cycle after the velocity byte is accepted. In that same cycle the key and velocity outputs show the two data bytes.
- R3: A status byte with upper nibble 0x8, followed by key and velocity, gives a note-off pulse for any velocity, zero included.
- R4: A 0x9 status byte followed by a velocity of zero gives a note-off pulse and no note-on pulse.
- R5: The low nibble of the status byte (the channel) has no effect on recognition or on the reported values.
- R6: Each pulse lasts exactly one clock. The two pulse lines are never high together.
- R7: After a complete note command, further key/velocity pairs with no new status byte are parsed as the same command type.
- R8: Bytes 0xF8 to 0xFF are ignored wherever they appear, even between the key and the velocity, and leave the parser state unchanged.
- R9: Any other status byte (0xA0 to 0xF7) makes the parser skip data bytes until the next status byte. No pulse is produced and the key and velocity outputs are unchanged.
- R10: A byte with bit 7 set always restarts parsing. A key byte collected before it is dropped.
- R11: Input bytes are consumed only in cycles where the valid strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byteIn | input | 8 | Byte from the serial receiver |
| byteValid | input | 1 | High for each cycle in which byteIn holds a new byte |
| noteOnPulse | output | 1 | One-clock pulse for a recognised note-on |
| noteOffPulse | output | 1 | One-clock pulse for a recognised note-off, either encoding |
| keyOut | output | 7 | Key number of the last recognised command |
| velOut | output | 7 | Velocity of the last recognised command |

## Verification
The bench sweeps all sixteen channels with both status types, a spread of keys and the velocity extremes. A parser that treats zero velocity on a 0x9 status as a note-on, or that decodes the channel nibble, fails there. Running-status pairs and real-time bytes inserted between key and velocity are aimed at parsers that either drop running status or let a clock byte reset the message. Sequences that switch to a controller or system status byte, and sequences that restart in the middle of a message, catch a parser that keeps collecting data for the old command. A bus that changes while the valid strobe is low catches a parser that samples unqualified bytes.

// File: rtl/midi_parser_pkg.sv
package midi_parser_pkg;

  localparam int NUM_STATES = 4;

  // bit positions inside the one-hot state vector
  localparam int S_IDLE = 0;
  localparam int S_KEY  = 1;
  localparam int S_VEL  = 2;
  localparam int S_SKIP = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic loadStatus; // latch the command type from the status byte
    logic loadKey;    // hold the key byte
    logic commit;     // velocity arrived: publish key/velocity and pulse
  } parseCtl_t;

endpackage

// File: rtl/midi_parser_ctrl.sv
module midi_parser_ctrl
  import midi_parser_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] byteIn,
  input  logic              byteValid,
  output parseCtl_t         ctl
);

  localparam logic [NUM_STATES-1:0] ST_IDLE = NUM_STATES'(1 << S_IDLE);
  localparam logic [NUM_STATES-1:0] ST_KEY  = NUM_STATES'(1 << S_KEY);
  localparam logic [NUM_STATES-1:0] ST_VEL  = NUM_STATES'(1 << S_VEL);
  localparam logic [NUM_STATES-1:0] ST_SKIP = NUM_STATES'(1 << S_SKIP);

  logic [NUM_STATES-1:0] state, nextState;
  logic isStatus, isRealTime, isNote;

  assign isStatus   = byteIn[BYTE_W-1];
  assign isRealTime = (byteIn[BYTE_W-1 -: 5] == 5'b11111);
  assign isNote     = (byteIn[BYTE_W-1 -: 3] == 3'b100);

  always_comb begin
    nextState = state;
    ctl       = '0;
    if (byteValid && !isRealTime) begin
      if (isStatus) begin
        if (isNote) begin
          nextState      = ST_KEY;
          ctl.loadStatus = 1'b1;
        end else begin
          nextState = ST_SKIP;
        end
      end else if (state[S_KEY]) begin
        ctl.loadKey = 1'b1;
        nextState   = ST_VEL;
      end else if (state[S_VEL]) begin
        ctl.commit = 1'b1;
        nextState  = ST_KEY;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(state) == 1); // R10

  AST_REALTIME_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (byteValid && byteIn >= BYTE_W'(8'hF8)) |=> $stable(state)); // R8

  AST_NO_VALID_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
    !byteValid |=> $stable(state)); // R11

  AST_SKIP_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
    state[S_SKIP] |-> !ctl.commit); // R9

endmodule

// File: rtl/midi_parser_dp.sv
module midi_parser_dp
  import midi_parser_pkg::*;
#(
  parameter int DATA_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] dataIn,
  input  parseCtl_t         ctl,
  output logic [DATA_W-1:0] keyOut,
  output logic [DATA_W-1:0] velOut,
  output logic              noteOnPulse,
  output logic              noteOffPulse
);

  // bit 4 of the status byte separates 0x9n (set) from 0x8n (clear)
  localparam int TYPE_BIT = 4;

  logic [DATA_W-1:0] keyHold;
  logic              cmdIsOn;
  logic              velNonZero;

  assign velNonZero = |dataIn;

  always_ff @(posedge clk) begin
    if (rst) begin
      keyHold      <= '0;
      cmdIsOn      <= 1'b0;
      keyOut       <= '0;
      velOut       <= '0;
      noteOnPulse  <= 1'b0;
      noteOffPulse <= 1'b0;
    end else begin
      noteOnPulse  <= 1'b0;
      noteOffPulse <= 1'b0;
      if (ctl.loadStatus) cmdIsOn <= dataIn[TYPE_BIT];
      if (ctl.loadKey)    keyHold <= dataIn;
      if (ctl.commit) begin
        keyOut <= keyHold;
        velOut <= dataIn;
        if (cmdIsOn && velNonZero) noteOnPulse  <= 1'b1;
        else                       noteOffPulse <= 1'b1;
      end
    end
  end

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(noteOnPulse && noteOffPulse)); // R6

  AST_ON_SINGLE: assert property (@(posedge clk) disable iff (rst)
    noteOnPulse |=> !noteOnPulse); // R6

  AST_OFF_SINGLE: assert property (@(posedge clk) disable iff (rst)
    noteOffPulse |=> !noteOffPulse); // R6

  AST_ON_HAS_VELOCITY: assert property (@(posedge clk) disable iff (rst)
    noteOnPulse |-> velOut != '0); // R4

  AST_COMMIT_PULSES: assert property (@(posedge clk) disable iff (rst)
    ctl.commit |=> (noteOnPulse || noteOffPulse)); // R2

  AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !ctl.commit |=> ($stable(keyOut) && $stable(velOut))); // R9

endmodule

// File: rtl/midi_note_parser.sv
module midi_note_parser
  import midi_parser_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] byteIn,
  input  logic              byteValid,
  output logic              noteOnPulse,
  output logic              noteOffPulse,
  output logic [BYTE_W-2:0] keyOut,
  output logic [BYTE_W-2:0] velOut
);

  localparam int DATA_W = BYTE_W - 1;

  parseCtl_t ctl;

  midi_parser_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .byteIn    (byteIn),
    .byteValid (byteValid),
    .ctl       (ctl)
  );

  midi_parser_dp #(.DATA_W(DATA_W)) u_dp (
    .clk          (clk),
    .rst          (rst),
    .dataIn       (byteIn[DATA_W-1:0]),
    .ctl          (ctl),
    .keyOut       (keyOut),
    .velOut       (velOut),
    .noteOnPulse  (noteOnPulse),
    .noteOffPulse (noteOffPulse)
  );

endmodule

// File: tb/midi_note_parser_tb.sv
`timescale 1ns/1ps
module midi_note_parser_tb;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] byteIn;
  logic       byteValid;
  logic       noteOnPulse, noteOffPulse;
  logic [6:0] keyOut, velOut;

  int checks = 0;
  int errors = 0;
  int onCnt  = 0;
  int offCnt = 0;
  logic prevOn = 1'b0, prevOff = 1'b0;
  logic done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  midi_note_parser u_dut (
    .clk(clk), .rst(rst), .byteIn(byteIn), .byteValid(byteValid),
    .noteOnPulse(noteOnPulse), .noteOffPulse(noteOffPulse),
    .keyOut(keyOut), .velOut(velOut)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pulse monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (noteOnPulse) onCnt++;
      if (noteOffPulse) offCnt++;
      if (noteOnPulse || noteOffPulse) begin
        check("R6 single-cycle exclusive pulse",
              int'((noteOnPulse && prevOn) || (noteOffPulse && prevOff) ||
                   (noteOnPulse && noteOffPulse)), 0);
      end
    end
    prevOn  = noteOnPulse;
    prevOff = noteOffPulse;
  end

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    byteIn    = b;
    byteValid = 1'b1;
    @(negedge clk);
    byteValid = 1'b0;
    byteIn    = 8'h00;
  endtask

  // status, key, velocity, then compare pulse counts and outputs
  task automatic noteMsg(input string req, input logic [7:0] st, input logic [6:0] k,
                         input logic [6:0] v, input int expOn, input int expOff,
                         input int expKey, input int expVel);
    int on0, off0;
    on0 = onCnt; off0 = offCnt;
    if (st[7]) sendByte(st);
    sendByte({1'b0, k});
    sendByte({1'b0, v});
    #1;
    check(req, onCnt - on0, expOn);
    check(req, offCnt - off0, expOff);
    check(req, int'(keyOut), expKey);
    check(req, int'(velOut), expVel);
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int on0, off0;
    logic [6:0] kv [4] = '{7'd0, 7'd1, 7'd64, 7'd127};
    rst = 1'b1; byteIn = 8'h00; byteValid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    check("R1 reset noteOn", int'(noteOnPulse), 0);
    check("R1 reset noteOff", int'(noteOffPulse), 0);
    check("R1 reset key", int'(keyOut), 0);
    check("R1 reset vel", int'(velOut), 0);
    // R1 no running status after reset
    noteMsg("R1 data without status", 8'h00, 7'h40, 7'h40, 0, 0, 0, 0);

    // R2 R3 R4 R5 sweep over channels, both status types, keys and velocities
    for (int ch = 0; ch < 16; ch++)
      for (int ty = 8; ty <= 9; ty++)
        for (int ki = 0; ki < 8; ki++)
          for (int vi = 0; vi < 4; vi++) begin
            int key, vel, isOn;
            key  = (ch * 8 + ki * 17 + ty) % 128;
            vel  = kv[vi];
            isOn = (ty == 9 && vel != 0) ? 1 : 0;
            noteMsg(ty == 8 ? "R3 R5 note-off status" :
                    (vel == 0 ? "R4 R5 zero-velocity note-on" : "R2 R5 note-on"),
                    8'((ty << 4) | ch), 7'(key), 7'(vel), isOn, 1 - isOn, key, vel);
          end

    // R7 running status on both types
    noteMsg("R7 first", 8'h93, 7'd60, 7'd90, 1, 0, 60, 90);
    for (int i = 0; i < 3; i++)
      noteMsg("R7 running note-on", 8'h00, 7'(61 + i), 7'(10 + i), 1, 0, 61 + i, 10 + i);
    noteMsg("R7 running zero vel", 8'h00, 7'd70, 7'd0, 0, 1, 70, 0);
    noteMsg("R7 off first", 8'h85, 7'd33, 7'd44, 0, 1, 33, 44);
    noteMsg("R7 running note-off", 8'h00, 7'd34, 7'd99, 0, 1, 34, 99);

    // R8 real-time bytes anywhere
    on0 = onCnt; off0 = offCnt;
    sendByte(8'h92); sendByte(8'hFE); sendByte(8'h15); sendByte(8'hF8);
    sendByte(8'hFF); sendByte(8'h25);
    #1;
    check("R8 realtime inside message on", onCnt - on0, 1);
    check("R8 realtime inside message off", offCnt - off0, 0);
    check("R8 key", int'(keyOut), 8'h15);
    check("R8 vel", int'(velOut), 8'h25);
    sendByte(8'hFA);
    noteMsg("R8 running kept across realtime", 8'h00, 7'd5, 7'd6, 1, 0, 5, 6);

    // R9 other status bytes start a skip
    noteMsg("R9 controller", 8'hB0, 7'd10, 7'd20, 0, 0, 5, 6);
    noteMsg("R9 skip continues", 8'h00, 7'd11, 7'd21, 0, 0, 5, 6);
    noteMsg("R9 program change", 8'hC4, 7'd1, 7'd2, 0, 0, 5, 6);
    noteMsg("R9 pitch bend", 8'hE0, 7'd0, 7'd64, 0, 0, 5, 6);
    noteMsg("R9 system common", 8'hF2, 7'd3, 7'd4, 0, 0, 5, 6);
    noteMsg("R9 sysex", 8'hF0, 7'd7, 7'd8, 0, 0, 5, 6);
    noteMsg("R9 after sysex end", 8'hF7, 7'd9, 7'd9, 0, 0, 5, 6);
    noteMsg("R9 recovery", 8'h81, 7'd100, 7'd101, 0, 1, 100, 101);

    // R10 restart in the middle of a message
    on0 = onCnt; off0 = offCnt;
    sendByte(8'h90); sendByte(8'h11); sendByte(8'h91); sendByte(8'h22); sendByte(8'h33);
    #1;
    check("R10 restart pulse count", onCnt - on0, 1);
    check("R10 restart key", int'(keyOut), 8'h22);
    check("R10 restart vel", int'(velOut), 8'h33);
    on0 = onCnt; off0 = offCnt;
    sendByte(8'h90); sendByte(8'h11); sendByte(8'hA0); sendByte(8'h22); sendByte(8'h33);
    #1;
    check("R10 abort to skip", onCnt + offCnt - on0 - off0, 0);
    check("R10 abort keeps key", int'(keyOut), 8'h22);

    // R11 bus activity without valid is ignored
    noteMsg("R11 setup", 8'h97, 7'd50, 7'd51, 1, 0, 50, 51);
    on0 = onCnt; off0 = offCnt;
    @(negedge clk);
    byteIn = 8'h80; repeat (3) @(negedge clk);
    byteIn = 8'h12; repeat (3) @(negedge clk);
    byteIn = 8'hB0; repeat (2) @(negedge clk);
    byteIn = 8'h00;
    #1;
    check("R11 no pulse while invalid", onCnt + offCnt - on0 - off0, 0);
    noteMsg("R11 running kept", 8'h00, 7'd52, 7'd53, 1, 0, 52, 53);

    // R1 reset mid-message forgets running status
    sendByte(8'h90); sendByte(8'h10);
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    #1;
    check("R1 reset clears key", int'(keyOut), 0);
    noteMsg("R1 no running after reset", 8'h00, 7'd20, 7'd30, 0, 0, 0, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule